// File: doc/BRIEF.md
# Sector-to-DMA Chunk Adapter

This block is the device-side engine behind a storage unit that keeps its data in fixed-size sectors. A command first loads the mode (optical or disk), the direction for disk mode, the starting block address, and the amount of work still owed. In optical mode that amount is a byte count for the packet. In disk mode it is a count of 512-byte sectors. After that, the DMA side hands over transfer requests one at a time. Each request carries a memory address and a byte length. The engine splits each request into chunks. For every chunk it runs a media access and a memory transfer, in the order the direction needs, and then advances the address, the remaining lengths and the block address.

In optical mode the sector is 2048 bytes, but a request may be as short as 512 bytes. The engine therefore keeps a byte offset into the current sector that survives from one request to the next. The block address steps forward only when that offset wraps past the end of a sector. When a request runs out, the engine pulses end-of-transfer. When the command's work runs out, it sets the ready and seek-complete status and pulses an interrupt. A media error ends the transfer at once and posts error status.

Media access is a request/acknowledge handshake with an error flag. Each memory chunk is a request/acknowledge handshake that carries an address, a length and a buffer offset.

Top module: `sector_dma_adapter`

## Requirements
- R1: After reset, statusOut is 0x00, intReason is 0x00, and mediaReq, memReq, dmaEnd and irq are all low.
- R2: A cmdStart pulse loads the command and clears the intra-sector offset to 0. From the next cycle statusOut reads 0x80 (busy, bit 7).
- R3: Optical chunk length is the smaller of 2048 and the bytes left in the request. Each chunk first reads 1 sector at the current block address (mediaWrite=0), then writes memory (memWrite=1).
- R4: In optical mode memBufOff equals the running offset. The offset grows by each chunk length modulo 2048, and the block address grows by one exactly when the offset wraps.
- R5: After each chunk the memory address grows by the chunk length, and the request length shrinks by it. The pending count shrinks by it too (bytes in optical mode, rounded-up sectors in disk mode), stopping at zero.
- R6: Chunking repeats while request bytes remain and pending work is non-zero. On exit, dmaEnd pulses for one cycle only if the request is exhausted, and this includes a zero-length request.
- R7: When optical pending bytes reach zero, statusOut becomes 0x50 (ready bit 6, seek-complete bit 4). intReason keeps bits 7:3 and becomes 3'b011 in bits 2:0 (bit 1 I/O, bit 0 command/data), and irq pulses for one cycle.
- R8: A disk chunk covers min(pending, 4) sectors, with its byte length clipped to the request. mediaSectors and the block-address advance use that byte length rounded up to whole 512-byte sectors.
- R9: A disk read does the media read before the memory write (memWrite=1). A disk write does the memory read (memWrite=0) before the media write (mediaWrite=1).
- R10: When disk pending sectors reach zero, statusOut becomes 0x50, irq pulses, and intReason is unchanged.
- R11: An acknowledge with mediaErr set causes a dmaEnd pulse, then statusOut 0x41 one cycle later, with no irq. The command is abandoned.
- R12: mediaReq and memReq stay high with stable fields until their acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Load a new command |
| cmdOptical | input | 1 | 1 = optical mode, 0 = disk mode |
| cmdWrite | input | 1 | Disk direction, 1 = memory to media |
| cmdLba | input | LBA_W | Starting block address |
| cmdCount | input | CNT_W | Pending bytes (optical) or sectors (disk) |
| cmdReason | input | 8 | Initial interrupt-reason value |
| reqValid | input | 1 | Transfer request strobe |
| reqAddr | input | ADDR_W | Request memory address |
| reqLen | input | LEN_W | Request byte length |
| mediaReq | output | 1 | Media access request |
| mediaWrite | output | 1 | Media access is a write |
| mediaLba | output | LBA_W | Media block address |
| mediaSectors | output | CNT_W | Sectors in this media access |
| mediaAck | input | 1 | Media access done |
| mediaErr | input | 1 | Media access failed (with mediaAck) |
| memReq | output | 1 | Memory chunk request |
| memWrite | output | 1 | 1 = buffer to memory, 0 = memory to buffer |
| memAddr | output | ADDR_W | Chunk memory address |
| memLen | output | LEN_W | Chunk byte length |
| memBufOff | output | OFF_W | Chunk start offset in the sector buffer |
| memAck | input | 1 | Memory chunk done |
| dmaEnd | output | 1 | End-of-transfer pulse |
| irq | output | 1 | Command-complete interrupt pulse |
| statusOut | output | 8 | Device status byte |
| intReason | output | 8 | Interrupt-reason byte |

## Verification
Optical commands are driven with runs of 512-byte requests, so several requests share one sector and the offset wraps. This separates an offset that persists across requests from one that resets, and a block address that steps on wrap from one that steps per chunk. Random lengths, some longer than a sector and some longer than the pending count, check clipping to the sector size, to the request and to the pending work. They also check the case where a request is left unfinished at command end without a dmaEnd. Disk reads and writes with odd lengths check the rounding up to whole sectors and the direction-dependent ordering. Directed zero-length and media-error cases check the end-of-transfer pulse on its own.

// File: rtl/sector_dma_pkg.sv
package sector_dma_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WREQ, S_STEP, S_MED, S_MEM, S_UPD, S_FIN, S_ENDERR, S_FAULT
  } ctlState_e;

  typedef struct packed {
    logic loadCmd;
    logic loadReq;
    logic commit;
    logic setDone;
    logic setErr;
    logic endXfer;
    logic raiseIrq;
  } ctlStrb_t;

  localparam logic [7:0] ST_BUSY = 8'h80;
  localparam logic [7:0] ST_DONE = 8'h50;
  localparam logic [7:0] ST_ERR  = 8'h41;

endpackage

// File: rtl/sector_dma_ctl.sv
module sector_dma_ctl
  import sector_dma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdStart,
  input  logic     reqValid,
  input  logic     mediaAck,
  input  logic     mediaErr,
  input  logic     memAck,
  input  logic     wrMode,
  input  logic     lenZero,
  input  logic     pendZero,
  output ctlStrb_t strb,
  output logic     mediaReq,
  output logic     memReq
);

  ctlState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strb     = '0;
    mediaReq = 1'b0;
    memReq   = 1'b0;
    unique case (stateQ)
      S_IDLE: if (cmdStart) begin
        strb.loadCmd = 1'b1;
        stateD = S_WREQ;
      end
      S_WREQ: begin
        if (cmdStart) strb.loadCmd = 1'b1;
        else if (reqValid) begin
          strb.loadReq = 1'b1;
          stateD = S_STEP;
        end
      end
      S_STEP: begin
        if (!lenZero && !pendZero) stateD = wrMode ? S_MEM : S_MED;
        else                       stateD = S_FIN;
      end
      S_MED: begin
        mediaReq = 1'b1;
        if (mediaAck) begin
          if (mediaErr)    stateD = S_ENDERR;
          else if (wrMode) stateD = S_UPD;
          else             stateD = S_MEM;
        end
      end
      S_MEM: begin
        memReq = 1'b1;
        if (memAck) stateD = wrMode ? S_MED : S_UPD;
      end
      S_UPD: begin
        strb.commit = 1'b1;
        stateD = S_STEP;
      end
      S_FIN: begin
        strb.endXfer = lenZero;
        if (pendZero) begin
          strb.setDone  = 1'b1;
          strb.raiseIrq = 1'b1;
          stateD = S_IDLE;
        end else begin
          stateD = S_WREQ;
        end
      end
      S_ENDERR: begin
        strb.endXfer = 1'b1;
        stateD = S_FAULT;
      end
      S_FAULT: begin
        strb.setErr = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  // R12: handshakes are held until acknowledged
  p_media_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    mediaReq && !mediaAck |=> mediaReq);
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);
  // R7/R10: interrupt only when pending work is gone
  p_irq_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.raiseIrq |-> pendZero);
  // R9: the two request kinds never overlap
  p_one_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(mediaReq && memReq));

endmodule

// File: rtl/sector_dma_dp.sv
module sector_dma_dp
  import sector_dma_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int LEN_W           = 16,
  parameter int CNT_W           = 16,
  parameter int LBA_W           = 32,
  parameter int OPT_SECT_BYTES  = 2048,
  parameter int DISK_SECT_BYTES = 512,
  parameter int BUF_SECTORS     = 4,
  localparam int OFF_W          = $clog2(OPT_SECT_BYTES),
  localparam int DSH            = $clog2(DISK_SECT_BYTES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic              cmdOptical,
  input  logic              cmdWrite,
  input  logic [LBA_W-1:0]  cmdLba,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [7:0]        cmdReason,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              wrMode,
  output logic              lenZero,
  output logic              pendZero,
  output logic              mediaWrite,
  output logic [LBA_W-1:0]  mediaLba,
  output logic [CNT_W-1:0]  mediaSectors,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W-1:0]  memLen,
  output logic [OFF_W-1:0]  memBufOff,
  output logic [7:0]        statusOut,
  output logic [7:0]        intReason
);

  localparam logic [LEN_W-1:0] OPT_LEN = LEN_W'(OPT_SECT_BYTES);
  localparam logic [CNT_W-1:0] BUF_CAP = CNT_W'(BUF_SECTORS);

  logic              optQ, wrQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  remLenQ;
  logic [LBA_W-1:0]  lbaQ;
  logic [CNT_W-1:0]  pendQ;
  logic [OFF_W-1:0]  offQ;
  logic [7:0]        statusQ, reasonQ;

  logic [CNT_W-1:0]  nCap, chunkSect, pendDec;
  logic [LEN_W-1:0]  capBytes, chunkLen;
  logic [LEN_W:0]    roundUp;
  logic [OFF_W:0]    offSum;

  always_comb begin
    nCap      = (pendQ < BUF_CAP) ? pendQ : BUF_CAP;
    capBytes  = LEN_W'(nCap) << DSH;
    if (optQ) chunkLen = (remLenQ < OPT_LEN)  ? remLenQ : OPT_LEN;
    else      chunkLen = (remLenQ < capBytes) ? remLenQ : capBytes;
    roundUp   = {1'b0, chunkLen} + (LEN_W+1)'(DISK_SECT_BYTES - 1);
    chunkSect = CNT_W'(roundUp >> DSH);
    offSum    = {1'b0, offQ} + (OFF_W+1)'(chunkLen);
    pendDec   = optQ ? CNT_W'(chunkLen) : chunkSect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      optQ <= 1'b0; wrQ <= 1'b0; addrQ <= '0; remLenQ <= '0; lbaQ <= '0;
      pendQ <= '0; offQ <= '0; statusQ <= 8'h00; reasonQ <= 8'h00;
    end else begin
      if (strb.loadCmd) begin
        optQ    <= cmdOptical;
        wrQ     <= cmdWrite && !cmdOptical;
        lbaQ    <= cmdLba;
        pendQ   <= cmdCount;
        offQ    <= '0;
        statusQ <= ST_BUSY;
        reasonQ <= cmdReason;
      end
      if (strb.loadReq) begin
        addrQ   <= reqAddr;
        remLenQ <= reqLen;
      end
      if (strb.commit) begin
        addrQ   <= addrQ + ADDR_W'(chunkLen);
        remLenQ <= remLenQ - chunkLen;
        pendQ   <= (pendQ > pendDec) ? pendQ - pendDec : '0;
        if (optQ) begin
          offQ <= offSum[OFF_W-1:0];
          lbaQ <= lbaQ + LBA_W'(offSum[OFF_W]);
        end else begin
          lbaQ <= lbaQ + LBA_W'(chunkSect);
        end
      end
      if (strb.setDone) begin
        statusQ <= ST_DONE;
        if (optQ) reasonQ <= {reasonQ[7:3], 3'b011};
      end
      if (strb.setErr) statusQ <= ST_ERR;
    end
  end

  assign wrMode       = wrQ;
  assign lenZero      = (remLenQ == '0);
  assign pendZero     = (pendQ == '0);
  assign mediaWrite   = wrQ;
  assign mediaLba     = lbaQ;
  assign mediaSectors = optQ ? CNT_W'(1) : chunkSect;
  assign memWrite     = !wrQ;
  assign memAddr      = addrQ;
  assign memLen       = chunkLen;
  assign memBufOff    = optQ ? offQ : '0;
  assign statusOut    = statusQ;
  assign intReason    = reasonQ;

  // R3/R8: a committed chunk is non-empty and fits the request
  p_chunk_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (chunkLen != '0) && (chunkLen <= remLenQ));
  // R5: pending work never grows except on a new command
  p_pend_mono_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCmd |=> pendQ <= $past(pendQ));
  // R11: end of transfer precedes the error status
  p_end_before_err_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |-> $past(strb.endXfer));
  // R4: an optical wrap advances the block address by exactly one
  p_wrap_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && optQ |=> lbaQ - $past(lbaQ) <= LBA_W'(1));

endmodule

// File: rtl/sector_dma_adapter.sv
module sector_dma_adapter
  import sector_dma_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int LEN_W           = 16,
  parameter int CNT_W           = 16,
  parameter int LBA_W           = 32,
  parameter int OPT_SECT_BYTES  = 2048,
  parameter int DISK_SECT_BYTES = 512,
  parameter int BUF_SECTORS     = 4,
  localparam int OFF_W          = $clog2(OPT_SECT_BYTES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdOptical,
  input  logic              cmdWrite,
  input  logic [LBA_W-1:0]  cmdLba,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [7:0]        cmdReason,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              mediaReq,
  output logic              mediaWrite,
  output logic [LBA_W-1:0]  mediaLba,
  output logic [CNT_W-1:0]  mediaSectors,
  input  logic              mediaAck,
  input  logic              mediaErr,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W-1:0]  memLen,
  output logic [OFF_W-1:0]  memBufOff,
  input  logic              memAck,
  output logic              dmaEnd,
  output logic              irq,
  output logic [7:0]        statusOut,
  output logic [7:0]        intReason
);

  ctlStrb_t strb;
  logic     wrMode, lenZero, pendZero;

  sector_dma_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .reqValid(reqValid),
    .mediaAck(mediaAck), .mediaErr(mediaErr), .memAck(memAck),
    .wrMode(wrMode), .lenZero(lenZero), .pendZero(pendZero),
    .strb(strb), .mediaReq(mediaReq), .memReq(memReq)
  );

  sector_dma_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .LBA_W(LBA_W),
    .OPT_SECT_BYTES(OPT_SECT_BYTES), .DISK_SECT_BYTES(DISK_SECT_BYTES),
    .BUF_SECTORS(BUF_SECTORS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cmdOptical(cmdOptical), .cmdWrite(cmdWrite), .cmdLba(cmdLba),
    .cmdCount(cmdCount), .cmdReason(cmdReason),
    .reqAddr(reqAddr), .reqLen(reqLen),
    .wrMode(wrMode), .lenZero(lenZero), .pendZero(pendZero),
    .mediaWrite(mediaWrite), .mediaLba(mediaLba), .mediaSectors(mediaSectors),
    .memWrite(memWrite), .memAddr(memAddr), .memLen(memLen),
    .memBufOff(memBufOff), .statusOut(statusOut), .intReason(intReason)
  );

  assign dmaEnd = strb.endXfer;
  assign irq    = strb.raiseIrq;

  // R6: end-of-transfer and interrupt are single-cycle pulses
  p_end_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    dmaEnd |=> !dmaEnd);
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

endmodule

// File: tb/sector_dma_adapter_tb.sv
module sector_dma_adapter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 0, cmdOptical = 0, cmdWrite = 0;
  logic [31:0] cmdLba = 0;
  logic [15:0] cmdCount = 0;
  logic [7:0]  cmdReason = 0;
  logic        reqValid = 0;
  logic [31:0] reqAddr = 0;
  logic [15:0] reqLen = 0;
  logic        mediaReq, mediaWrite, mediaAck = 0, mediaErr = 0;
  logic [31:0] mediaLba;
  logic [15:0] mediaSectors;
  logic        memReq, memWrite, memAck = 0;
  logic [31:0] memAddr;
  logic [15:0] memLen;
  logic [10:0] memBufOff;
  logic        dmaEnd, irq;
  logic [7:0]  statusOut, intReason;

  always #2.5 clk = ~clk;

  sector_dma_adapter u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdOptical(cmdOptical),
    .cmdWrite(cmdWrite), .cmdLba(cmdLba), .cmdCount(cmdCount),
    .cmdReason(cmdReason), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .mediaReq(mediaReq), .mediaWrite(mediaWrite),
    .mediaLba(mediaLba), .mediaSectors(mediaSectors), .mediaAck(mediaAck),
    .mediaErr(mediaErr), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memLen(memLen), .memBufOff(memBufOff),
    .memAck(memAck), .dmaEnd(dmaEnd), .irq(irq), .statusOut(statusOut),
    .intReason(intReason)
  );

  int nChecks = 0, nFails = 0, endCnt = 0, irqCnt = 0;
  bit mOpt, mWr;
  int unsigned mLba, mPend, mOff;
  logic [7:0] mReason;

  always @(negedge clk) if (rstN) begin
    if (dmaEnd) endCnt++;
    if (irq) irqCnt++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned minU(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic int unsigned roundSect(input int unsigned len);
    return (len + 511) / 512;
  endfunction

  task automatic waitFor(input bit media);
    for (int i = 0; i < 100; i++) begin
      if (media ? mediaReq : memReq) return;
      @(negedge clk);
    end
    check(0, media ? "R12 mediaReq timeout" : "R12 memReq timeout", 0, 1);
  endtask

  task automatic mediaStep(input bit wr, input int unsigned ns, input bit err);
    logic [31:0] lbaSeen;
    waitFor(1);
    check(mediaReq == 1'b1, "R9 media request present", mediaReq, 1);
    check(memReq == 1'b0, "R9 media access not overlapping memory", memReq, 0);
    check(mediaLba == mLba, mOpt ? "R4 optical media lba" : "R8 disk media lba", mediaLba, mLba);
    check(mediaSectors == ns, mOpt ? "R3 optical one sector" : "R8 disk sector count", mediaSectors, ns);
    check(mediaWrite == wr, "R9 media direction", mediaWrite, wr);
    lbaSeen = mediaLba;
    repeat ($urandom % 3) @(negedge clk);
    check(mediaReq && mediaLba == lbaSeen, "R12 media request held", mediaLba, lbaSeen);
    mediaAck = 1; mediaErr = err;
    @(negedge clk);
    mediaAck = 0; mediaErr = 0;
  endtask

  task automatic memStep(input int unsigned ad, input int unsigned cl, input int unsigned off, input bit toMem);
    logic [31:0] adSeen;
    waitFor(0);
    check(mediaReq == 1'b0, "R9 memory access not overlapping media", mediaReq, 0);
    check(memAddr == ad, "R5 chunk memory address", memAddr, ad);
    check(memLen == cl, mOpt ? "R3 optical chunk length" : "R8 disk chunk length", memLen, cl);
    check(memBufOff == off, "R4 buffer offset", memBufOff, off);
    check(memWrite == toMem, "R9 memory direction", memWrite, toMem);
    adSeen = memAddr;
    repeat ($urandom % 3) @(negedge clk);
    check(memReq && memAddr == adSeen, "R12 memory request held", memAddr, adSeen);
    memAck = 1;
    @(negedge clk);
    memAck = 0;
  endtask

  task automatic startCmd(input bit opt, input bit wr, input int unsigned lba,
                          input int unsigned cnt, input logic [7:0] rsn);
    @(negedge clk);
    cmdStart = 1; cmdOptical = opt; cmdWrite = wr; cmdLba = lba;
    cmdCount = cnt[15:0]; cmdReason = rsn;
    @(negedge clk);
    cmdStart = 0;
    check(statusOut == 8'h80, "R2 busy status after command", statusOut, 8'h80);
    mOpt = opt; mWr = wr && !opt; mLba = lba; mPend = cnt; mOff = 0; mReason = rsn;
  endtask

  task automatic doReq(input int unsigned a, input int unsigned l, input bit err);
    int unsigned remL, ad, cl, ns, dec;
    int e0, i0;
    remL = l; ad = a; e0 = endCnt; i0 = irqCnt;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqLen = l[15:0];
    @(negedge clk);
    reqValid = 0;
    while (remL > 0 && mPend > 0) begin
      if (mOpt) begin
        cl = minU(remL, 2048); ns = 1; dec = cl;
      end else begin
        cl = minU(remL, minU(mPend, 4) * 512); ns = roundSect(cl); dec = ns;
      end
      if (!mWr) begin
        mediaStep(0, ns, err);
        if (err) begin
          repeat (6) @(negedge clk);
          check(endCnt - e0 == 1, "R11 dmaEnd on media error", endCnt - e0, 1);
          check(irqCnt - i0 == 0, "R11 no irq on media error", irqCnt - i0, 0);
          check(statusOut == 8'h41, "R11 error status", statusOut, 8'h41);
          mPend = 0;
          return;
        end
        memStep(ad, cl, mOpt ? mOff : 0, 1);
      end else begin
        memStep(ad, cl, 0, 0);
        mediaStep(1, ns, 0);
      end
      ad += cl; remL -= cl;
      mPend = (mPend > dec) ? mPend - dec : 0;
      if (mOpt) begin
        mOff += cl; mLba += mOff / 2048; mOff = mOff % 2048;
      end else begin
        mLba += ns;
      end
    end
    repeat (6) @(negedge clk);
    check(endCnt - e0 == ((remL == 0) ? 1 : 0), "R6 dmaEnd count", endCnt - e0, (remL == 0) ? 1 : 0);
    check(irqCnt - i0 == ((mPend == 0) ? 1 : 0), mOpt ? "R7 irq count" : "R10 irq count",
          irqCnt - i0, (mPend == 0) ? 1 : 0);
    if (mPend == 0) begin
      if (mOpt) mReason = {mReason[7:3], 3'b011};
      check(statusOut == 8'h50, mOpt ? "R7 done status" : "R10 done status", statusOut, 8'h50);
      check(intReason == mReason, mOpt ? "R7 reason bits" : "R10 reason unchanged", intReason, mReason);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(statusOut == 8'h00, "R1 reset status", statusOut, 0);
    check(intReason == 8'h00, "R1 reset reason", intReason, 0);
    check(!mediaReq && !memReq && !dmaEnd && !irq, "R1 reset strobes low",
          {mediaReq, memReq, dmaEnd, irq}, 0);

    // R4 directed: 512-byte requests drain 2048-byte sectors, offset wraps
    startCmd(1, 0, 100, 5120, 8'hA5);
    for (int i = 0; i < 10; i++) doReq(32'h1000 + i * 512, 512, 0);

    // R6 directed: zero-length request pulses dmaEnd without any chunk
    startCmd(1, 0, 7, 4096, 8'hF8);
    doReq(32'h2000, 0, 0);
    // R3 directed: long request clipped to sector size, then to pending bytes
    doReq(32'h3000, 5000, 0);

    // R8 directed: odd disk length rounds up to whole sectors
    startCmd(0, 0, 50, 9, 8'h12);
    doReq(32'h4000, 1300, 0);
    doReq(32'h5000, 8192, 0);

    // R9 directed: disk write ordering
    startCmd(0, 1, 900, 6, 8'h00);
    doReq(32'h6000, 3072, 0);

    // R11 directed: media error
    startCmd(1, 0, 33, 4096, 8'h00);
    doReq(32'h7000, 1024, 1);

    // R2 offset cleared by a fresh command after a partial sector
    startCmd(1, 0, 10, 3000, 8'h40);
    doReq(32'h8000, 700, 0);
    startCmd(1, 0, 20, 1000, 8'h40);
    doReq(32'h9000, 1000, 0);

    // random mix
    for (int c = 0; c < 24; c++) begin
      bit opt, wr;
      int unsigned cnt;
      opt = ($urandom % 2) == 1;
      wr  = !opt && (($urandom % 2) == 1);
      cnt = opt ? 1 + $urandom % 6000 : 1 + $urandom % 10;
      startCmd(opt, wr, $urandom % 100000, cnt, 8'($urandom));
      for (int r = 0; r < 40 && mPend > 0; r++) begin
        int unsigned sel, len;
        sel = $urandom % 10;
        if (sel < 4)       len = 512;
        else if (sel < 6)  len = 2048;
        else if (sel == 6) len = 0;
        else               len = 1 + $urandom % 3000;
        doReq($urandom & 32'hFFFF_FFF0, len, 0);
      end
    end
    finishRun();
  end

endmodule